// File: doc/BRIEF.md
# External Bus Controller with Ready-Wait

This block turns single requests from a small processor core into read or write cycles on an external parallel bus. The core raises a request with address, write data, byte enables and a direction flag, and holds it until a one-cycle acknowledge arrives. Read data is returned with that acknowledge. On the pin side the block drives a 20-bit address, a 16-bit data bus with its output enable, four one-hot chip selects, a read strobe, one write strobe per byte lane, a high-byte enable and an address latch enable.

The top address bits pick one of four regions. Each region has a 2-bit software wait field and a wait-control bit. When that bit is 0, a slow device can stretch the cycle through the ready input. Ready is looked at only in the final cycle of the strobe phase, after all software waits have passed. While ready is low, the cycle is held with every pin frozen.

An address/data mode input selects between two bus styles. In separate mode the strobe phase starts at once. In multiplexed mode an address phase comes first: the low address bits go out on the data lines and the address latch enable is high for that cycle. One bus clock period is one cycle of `clk`.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: The chip select output is one-hot for region `core_addr[19:18]` (bit n for region n) while a cycle is in progress, and all zero when idle and in the acknowledge cycle.
- R2: Software wait field value s (bits [2n+1:2n] of `cfg_sw_wait` for region n) gives s+1 wait states. With ready high, the strobe phase lasts s+2 cycles.
- R3: When the region's bit n of `cfg_wait_n` is 1, the ready input is ignored and the strobe phase lasts exactly s+2 cycles.
- R4: When that bit is 0, ready is sampled at the end of the final strobe cycle, after the software waits. Each low sample adds one more cycle, and the cycle ends at the first high sample.
- R5: While a cycle is stretched by ready, address, chip selects, read and write strobes, high-byte enable, address latch enable, data out and data output enable all keep their values.
- R6: With `cfg_mux`=1, one address cycle comes before the strobe phase. In it `bus_ale`=1, `bus_d_o` carries address bits [15:0] and `bus_d_oe`=1. With `cfg_mux`=0, `bus_ale` never goes high.
- R7: During a write strobe, `bus_wr[i]` equals `core_be[i]` (bit 0 is the low byte), `bus_d_o` carries the write data and `bus_d_oe`=1. During a read, `bus_rd`=1 and `bus_wr`=0. Throughout the cycle, `bus_bhe` equals `core_be[1]`.
- R8: For a read, `core_rdata` holds the value on `bus_d_i` at the clock edge that ends the cycle, and is valid while `core_ack` is high.
- R9: `core_ack` is a single-cycle pulse, one per accepted request. A request is accepted only while the controller is idle and not acknowledging.
- R10: The address, data, byte enables, direction and the region's settings are latched when a request is accepted. Changes to the core inputs or configuration during the cycle do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus clock period per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core request, held until acknowledge |
| core_wr | input | 1 | 1 = write, 0 = read |
| core_addr | input | 20 | Core address |
| core_wdata | input | 16 | Write data |
| core_be | input | 2 | Byte enables, bit 0 low byte |
| core_ack | output | 1 | One-cycle completion pulse |
| core_rdata | output | 16 | Captured read data |
| cfg_mux | input | 1 | 1 = multiplexed address/data mode |
| cfg_wait_n | input | 4 | Per region: 0 = ready honoured |
| cfg_sw_wait | input | 8 | Per region 2-bit software wait field |
| bus_addr | output | 20 | External address |
| bus_cs | output | 4 | One-hot chip selects |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 2 | Per-byte-lane write strobes |
| bus_bhe | output | 1 | High byte enable |
| bus_ale | output | 1 | Address latch enable |
| bus_d_o | output | 16 | Data/address out |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_d_i | input | 16 | Data in |
| bus_rdy | input | 1 | External ready, low stretches the cycle |

## Verification
A wrong wait counter or a mis-latched region setting shows up as a strobe phase whose length differs from s+2 or from the ready-stretched length. The acknowledge then arrives early or late in that same transfer. If the freeze logic is wrong, a pin changes during the very first stretched cycle. A bad decode or latch shows at once on the chip selects, strobes or data lanes of the first strobe cycle. If the capture edge is wrong, the read data seen with the acknowledge differs from what the device drove in the final cycle.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
   localparam int SW_BITS = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_STRB = 2'd2
   } xbc_state_e;

   typedef struct packed {
      logic               rdy_en;
      logic [SW_BITS-1:0] sw;
   } xbc_rcfg_t;
endpackage

// File: rtl/xbc_region_dec.sv
module xbc_region_dec
   import xbc_pkg::*;
#(
   parameter int AW   = 20,
   parameter int NREG = 4
) (
   input  logic [AW-1:0]           addr,
   input  logic [NREG-1:0]         wait_n,
   input  logic [NREG*SW_BITS-1:0] sw_wait,
   output logic [NREG-1:0]         cs_vec,
   output xbc_rcfg_t               sel_cfg
);
   localparam int RB = $clog2(NREG);

   if (NREG < 2 || (1 << RB) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (RB >= AW) begin : g_bad_aw
      $error("AW too small for region decode");
   end

   logic [RB-1:0] idx;
   assign idx = addr[AW-1 -: RB];

   for (genvar g = 0; g < NREG; g++) begin : g_hit
      assign cs_vec[g] = (idx == RB'(g));
   end

   always_comb begin
      sel_cfg = '0;
      for (int i = 0; i < NREG; i++) begin
         if (cs_vec[i]) begin
            sel_cfg.rdy_en = ~wait_n[i];
            sel_cfg.sw     = sw_wait[i*SW_BITS +: SW_BITS];
         end
      end
   end

   always_comb begin
      a_dec_onehot_r1 : assert ($onehot(cs_vec));
   end
endmodule

// File: rtl/xbc_wait_timer.sv
module xbc_wait_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          run,
   output logic          last
);
   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (load)            cnt <= load_val;
      else if (run && cnt != 0) cnt <= cnt - CW'(1);
   end

   assign last = (cnt == '0);

   p_cnt_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (last && !load) |=> last);
   p_cnt_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && !last && !load) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/xbc_pin_drive.sv
module xbc_pin_drive
   import xbc_pkg::*;
#(
   parameter int AW   = 20,
   parameter int DW   = 16,
   parameter int NREG = 4,
   parameter int BEW  = DW / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xbc_state_e        st,
   input  logic [AW-1:0]     lat_addr,
   input  logic [DW-1:0]     lat_wdata,
   input  logic [BEW-1:0]    lat_be,
   input  logic              lat_wr,
   input  logic [NREG-1:0]   lat_cs,
   output logic [AW-1:0]     bus_addr,
   output logic [NREG-1:0]   bus_cs,
   output logic              bus_rd,
   output logic [BEW-1:0]    bus_wr,
   output logic              bus_bhe,
   output logic              bus_ale,
   output logic [DW-1:0]     bus_d_o,
   output logic              bus_d_oe
);
   logic [DW-1:0] addr_lo;
   logic          active;
   logic          strb;

   if (AW >= DW) begin : g_addr_trunc
      assign addr_lo = lat_addr[DW-1:0];
   end else begin : g_addr_ext
      assign addr_lo = {{(DW-AW){1'b0}}, lat_addr};
   end

   if (BEW > 1) begin : g_bhe
      assign bus_bhe = active & (|lat_be[BEW-1:1]);
   end else begin : g_no_bhe
      assign bus_bhe = 1'b0;
   end

   assign active   = (st != ST_IDLE);
   assign strb     = (st == ST_STRB);
   assign bus_addr = lat_addr;
   assign bus_cs   = active ? lat_cs : '0;
   assign bus_ale  = (st == ST_ADDR);
   assign bus_rd   = strb & ~lat_wr;
   assign bus_wr   = (strb & lat_wr) ? lat_be : '0;
   assign bus_d_o  = (st == ST_ADDR) ? addr_lo : lat_wdata;
   assign bus_d_oe = (st == ST_ADDR) | (strb & lat_wr);

   p_ale_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> (!bus_rd && bus_wr == '0 && bus_d_oe));
   p_rw_excl_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |-> (bus_wr == '0 && !bus_d_oe));
   p_cs_single_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bus_cs));
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
   import xbc_pkg::*;
#(
   parameter int AW   = 20,
   parameter int DW   = 16,
   parameter int NREG = 4,
   parameter int BEW  = DW / 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    core_req,
   input  logic                    core_wr,
   input  logic [AW-1:0]           core_addr,
   input  logic [DW-1:0]           core_wdata,
   input  logic [BEW-1:0]          core_be,
   output logic                    core_ack,
   output logic [DW-1:0]           core_rdata,
   input  logic                    cfg_mux,
   input  logic [NREG-1:0]         cfg_wait_n,
   input  logic [NREG*SW_BITS-1:0] cfg_sw_wait,
   output logic [AW-1:0]           bus_addr,
   output logic [NREG-1:0]         bus_cs,
   output logic                    bus_rd,
   output logic [BEW-1:0]          bus_wr,
   output logic                    bus_bhe,
   output logic                    bus_ale,
   output logic [DW-1:0]           bus_d_o,
   output logic                    bus_d_oe,
   input  logic [DW-1:0]           bus_d_i,
   input  logic                    bus_rdy
);
   localparam int CW = SW_BITS + 1;

   if (DW % 8 != 0 || BEW != DW / 8) begin : g_bad_dw
      $error("DW must be a multiple of 8 and BEW must equal DW/8");
   end

   xbc_state_e      st;
   logic [AW-1:0]   lat_addr;
   logic [DW-1:0]   lat_wdata;
   logic [BEW-1:0]  lat_be;
   logic            lat_wr;
   logic [NREG-1:0] lat_cs;
   logic            lat_rdy_en;
   logic [NREG-1:0] dec_cs;
   xbc_rcfg_t       dec_cfg;
   logic            accept;
   logic            last;
   logic            finish;

   xbc_region_dec #(.AW(AW), .NREG(NREG)) u_dec (
      .addr    (core_addr),
      .wait_n  (cfg_wait_n),
      .sw_wait (cfg_sw_wait),
      .cs_vec  (dec_cs),
      .sel_cfg (dec_cfg)
   );

   assign accept = (st == ST_IDLE) && core_req && !core_ack;
   assign finish = (st == ST_STRB) && last && (bus_rdy || !lat_rdy_en);

   xbc_wait_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (CW'(dec_cfg.sw) + CW'(1)),
      .run      (st == ST_STRB),
      .last     (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         core_ack   <= 1'b0;
         core_rdata <= '0;
         lat_addr   <= '0;
         lat_wdata  <= '0;
         lat_be     <= '0;
         lat_wr     <= 1'b0;
         lat_cs     <= '0;
         lat_rdy_en <= 1'b0;
      end else begin
         core_ack <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  lat_addr   <= core_addr;
                  lat_wdata  <= core_wdata;
                  lat_be     <= core_be;
                  lat_wr     <= core_wr;
                  lat_cs     <= dec_cs;
                  lat_rdy_en <= dec_cfg.rdy_en;
                  st         <= cfg_mux ? ST_ADDR : ST_STRB;
               end
            end
            ST_ADDR: st <= ST_STRB;
            ST_STRB: begin
               if (finish) begin
                  st       <= ST_IDLE;
                  core_ack <= 1'b1;
                  if (!lat_wr) core_rdata <= bus_d_i;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   xbc_pin_drive #(.AW(AW), .DW(DW), .NREG(NREG), .BEW(BEW)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .st        (st),
      .lat_addr  (lat_addr),
      .lat_wdata (lat_wdata),
      .lat_be    (lat_be),
      .lat_wr    (lat_wr),
      .lat_cs    (lat_cs),
      .bus_addr  (bus_addr),
      .bus_cs    (bus_cs),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_bhe   (bus_bhe),
      .bus_ale   (bus_ale),
      .bus_d_o   (bus_d_o),
      .bus_d_oe  (bus_d_oe)
   );

   p_freeze_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STRB && last && lat_rdy_en && !bus_rdy) |=>
         ($stable(bus_addr) && $stable(bus_cs) && $stable(bus_rd) &&
          $stable(bus_wr) && $stable(bus_bhe) && $stable(bus_ale) &&
          $stable(bus_d_o) && $stable(bus_d_oe) && !core_ack));
   p_ignore_rdy_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_STRB && last && !lat_rdy_en) |=> core_ack);
   p_ack_pulse_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      core_ack |=> !core_ack);
   p_ack_idle_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      core_ack |-> (bus_cs == '0 && !bus_rd && bus_wr == '0));
   p_rdata_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (finish && !lat_wr) |=> (core_rdata == $past(bus_d_i)));
endmodule

// File: tb/tb_xbus_wait_ctrl.sv
module tb_xbus_wait_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_req = 1'b0;
   logic        core_wr = 1'b0;
   logic [19:0] core_addr = '0;
   logic [15:0] core_wdata = '0;
   logic [1:0]  core_be = '0;
   logic        core_ack;
   logic [15:0] core_rdata;
   logic        cfg_mux = 1'b0;
   logic [3:0]  cfg_wait_n = '0;
   logic [7:0]  cfg_sw_wait = '0;
   logic [19:0] bus_addr;
   logic [3:0]  bus_cs;
   logic        bus_rd;
   logic [1:0]  bus_wr;
   logic        bus_bhe;
   logic        bus_ale;
   logic [15:0] bus_d_o;
   logic        bus_d_oe;
   logic [15:0] bus_d_i;
   logic        bus_rdy = 1'b1;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   assign bus_d_i = bus_addr[15:0] ^ 16'hC35A;

   xbus_wait_ctrl dut (
      .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_wr(core_wr),
      .core_addr(core_addr), .core_wdata(core_wdata), .core_be(core_be),
      .core_ack(core_ack), .core_rdata(core_rdata), .cfg_mux(cfg_mux),
      .cfg_wait_n(cfg_wait_n), .cfg_sw_wait(cfg_sw_wait),
      .bus_addr(bus_addr), .bus_cs(bus_cs), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_bhe(bus_bhe), .bus_ale(bus_ale), .bus_d_o(bus_d_o),
      .bus_d_oe(bus_d_oe), .bus_d_i(bus_d_i), .bus_rdy(bus_rdy)
   );

   function automatic int exp_len(input int sw, input bit en, input int k);
      int w = sw + 1;
      if (en && k > w) return k + 1;
      return w + 1;
   endfunction

   function automatic logic [15:0] exp_rd(input logic [19:0] a);
      return a[15:0] ^ 16'hC35A;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [19:0] a, input logic [15:0] wd, input logic [1:0] be,
                       input bit wr, input bit mux, input int k, input bit disturb);
      int          region;
      int          sw;
      bit          en;
      int          w;
      int          elen;
      int          strb;
      int          ale_n;
      int          cyc;
      bit          done;
      bit          pin_ok;
      logic [3:0]  sv_wn;
      logic [7:0]  sv_sw;
      logic [19:0] s_addr;
      logic [3:0]  s_cs;
      logic [1:0]  s_wr;
      logic        s_rd;
      logic [15:0] s_do;
      logic        s_oe;
      logic        s_bhe;
      region = int'(a[19:18]);
      sw     = int'(cfg_sw_wait[2*region +: 2]);
      en     = !cfg_wait_n[region];
      w      = sw + 1;
      elen   = exp_len(sw, en, k);
      sv_wn  = cfg_wait_n;
      sv_sw  = cfg_sw_wait;
      strb = 0; ale_n = 0; cyc = 0; done = 0;
      s_addr = '0; s_cs = '0; s_wr = '0; s_rd = 0; s_do = '0; s_oe = 0; s_bhe = 0;
      @(negedge clk);
      core_req = 1'b1; core_wr = wr; core_addr = a; core_wdata = wd; core_be = be;
      cfg_mux = mux; bus_rdy = 1'b1;
      while (!done && cyc < 200) begin
         @(negedge clk);
         cyc++;
         if (disturb && cyc == 2) begin
            core_addr = ~a; core_wdata = ~wd; core_be = ~be; core_wr = ~wr;
            cfg_wait_n = ~sv_wn; cfg_sw_wait = ~sv_sw; cfg_mux = ~mux;
         end
         if (core_ack) begin
            done = 1;
            core_req = 1'b0;
            bus_rdy = 1'b1;
            check(bus_cs == 4'b0 && !bus_rd && bus_wr == 2'b0, "R1 chip selects idle at ack",
                  int'(bus_cs), 0);
            if (!wr) check(core_rdata == exp_rd(a), "R8 read data", int'(core_rdata), int'(exp_rd(a)));
         end else if (bus_ale) begin
            ale_n++;
            check(bus_d_o == a[15:0] && bus_d_oe && bus_cs == 4'(1 << region),
                  "R6 address phase", int'(bus_d_o), int'(a[15:0]));
            bus_rdy = 1'b1;
         end else if (bus_rd || bus_wr != 2'b0) begin
            pin_ok = (bus_addr == a) && (bus_cs == 4'(1 << region)) && (bus_bhe == be[1]);
            check(pin_ok, "R1 address and chip select", int'(bus_cs), 1 << region);
            if (wr)
               check(bus_wr == be && !bus_rd && bus_d_o == wd && bus_d_oe,
                     "R7 write strobes and data", int'({bus_wr, bus_d_o}), int'({be, wd}));
            else
               check(bus_rd && bus_wr == 2'b0 && !bus_d_oe, "R7 read strobe",
                     int'({bus_rd, bus_wr}), 4);
            if (strb == w) begin
               s_addr = bus_addr; s_cs = bus_cs; s_wr = bus_wr; s_rd = bus_rd;
               s_do = bus_d_o; s_oe = bus_d_oe; s_bhe = bus_bhe;
            end else if (strb > w) begin
               check(bus_addr == s_addr && bus_cs == s_cs && bus_wr == s_wr && bus_rd == s_rd &&
                     bus_d_o == s_do && bus_d_oe == s_oe && bus_bhe == s_bhe && !bus_ale,
                     "R5 pins frozen during ready wait", int'(bus_addr), int'(s_addr));
            end
            bus_rdy = (strb >= k);
            strb++;
         end else begin
            bus_rdy = 1'b1;
         end
      end
      if (!done) check(0, "R9 no acknowledge (watchdog)", cyc, elen);
      if (!en) check(strb == elen, "R3 ready ignored, length", strb, elen);
      else if (k > w) check(strb == elen, "R4 ready-stretched length", strb, elen);
      else check(strb == elen, "R2 software wait length", strb, elen);
      if (disturb) check(strb == elen && ale_n == (mux ? 1 : 0), "R10 latched at accept", strb, elen);
      check(ale_n == (mux ? 1 : 0), "R6 address latch pulses", ale_n, mux ? 1 : 0);
      cfg_wait_n = sv_wn;
      cfg_sw_wait = sv_sw;
      @(negedge clk);
      check(!core_ack && bus_cs == 4'b0, "R9 single ack pulse", int'(core_ack), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(bus_cs == 4'b0 && !bus_rd && bus_wr == 2'b0 && !bus_ale && !bus_d_oe && !core_ack,
            "R1 reset pins idle", int'({bus_cs, bus_rd, bus_wr, bus_ale}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!core_ack && bus_cs == 4'b0, "R9 idle after reset", int'(core_ack), 0);

      // R2: field 00 gives one software wait, field 11 gives four
      cfg_wait_n = 4'b1111; cfg_sw_wait = 8'b11_10_01_00;
      xfer(20'h01234, 16'h0, 2'b11, 1'b0, 1'b0, 0, 1'b0);
      xfer(20'hC5678, 16'hBEEF, 2'b11, 1'b1, 1'b0, 0, 1'b0);
      // R3: ready held low in a region with the control bit set
      xfer(20'h4ABCD, 16'h0, 2'b01, 1'b0, 1'b0, 9, 1'b0);
      // R4/R5: ready low past the software waits in an enabled region
      cfg_wait_n = 4'b0000;
      xfer(20'h00010, 16'h0, 2'b11, 1'b0, 1'b0, 7, 1'b0);
      xfer(20'h8F00F, 16'h1234, 2'b10, 1'b1, 1'b0, 5, 1'b0);
      // R4: ready low only during the software waits has no effect
      xfer(20'hC0002, 16'h0, 2'b11, 1'b0, 1'b0, 3, 1'b0);
      // R6: multiplexed mode, read and stretched write
      xfer(20'h4A5A5, 16'h0, 2'b11, 1'b0, 1'b1, 0, 1'b0);
      xfer(20'h84321, 16'h55AA, 2'b01, 1'b1, 1'b1, 6, 1'b0);
      // R10: core inputs and configuration disturbed mid-cycle
      cfg_wait_n = 4'b1010;
      xfer(20'h41111, 16'h0, 2'b11, 1'b0, 1'b0, 6, 1'b1);
      xfer(20'h02222, 16'h7E7E, 2'b11, 1'b1, 1'b1, 6, 1'b1);

      for (int i = 0; i < 80; i++) begin
         cfg_wait_n  = 4'($urandom);
         cfg_sw_wait = 8'($urandom);
         xfer(20'($urandom), 16'($urandom), 2'($urandom_range(1, 3)),
              1'($urandom), 1'($urandom), int'($urandom_range(0, 8)), 1'($urandom_range(0, 7) == 0));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule